// File: doc/BRIEF.md
# Triple-DES CBC Block Decryptor

This block turns a stream of 64-bit ciphertext blocks back into plaintext. It uses triple DES with separate keys for each of the three DES passes, and it chains the blocks in cipher block chaining (CBC) mode. One Feistel round datapath is reused for all 48 rounds of a block. A 64-bit state register captures the round result on every clock. The three passes run in the order decrypt, encrypt, decrypt. The initial and final permutations are applied only where a pass begins and where it ends. Subkeys are generated on the fly:
- During the encrypt pass the two 28-bit key halves rotate left.
- During the decrypt passes they rotate right, starting from the final key state, so the subkeys come out in reverse order.

The block has a single input holding register. A new ciphertext block can therefore be accepted while the previous one is still running. After the previous block writes back its result, the held block starts on the next clock. Each finished block is XORed with the ciphertext that came before it in the stream, and the result is presented with a one-cycle valid pulse. The chaining register can be reloaded with an initialization value at any time. Reloading it restarts the chain.

Top module: `tdes_cbc_dec`

## Requirements
- R1: During and after reset, `pt_valid` is 0, `busy` is 0 and `ct_ready` is 1.
- R2: Each key port carries 56 bits: a 64-bit DES key with the lowest bit of each byte removed, bytes kept most significant first. For a block C the DES result is D(key_p3, E(key_p2, D(key_p1, C))). The passes run in that order: pass 1 decrypts with `key_p1`, pass 2 encrypts with `key_p2`, pass 3 decrypts with `key_p3`.
- R3: Each plaintext equals the triple-DES result XORed with the preceding ciphertext block. The first block after an IV load is XORed with the loaded IV instead.
- R4: When all three keys are equal, the output is a single DES decryption. Key 133457799BBCDFF1 (64-bit form), ciphertext 85E813540F0AB405 and IV 0 give 0123456789ABCDEF.
- R5: For a block accepted while the engine is idle, `pt_valid` rises on the 49th rising edge after the accepting edge: one start edge plus 48 round edges.
- R6: While a block is being processed, one further block is accepted and held. Back-to-back blocks produce plaintext pulses exactly 49 cycles apart, which is under 64 cycles per block.
- R7: `pt_valid` is high for exactly one cycle. `pt_out` holds its value until the next pulse.
- R8: Loading the IV again and resending a stream's first ciphertext reproduces that stream's first plaintext.
- R9: `ct_valid` asserted while `ct_ready` is 0 has no effect: no block is taken and no extra output appears.
- R10: `busy` is high from the edge that accepts a block until the edge that raises the last pending `pt_valid`. At that edge it falls.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| iv_load | input | 1 | Loads `iv_in` into the chaining register |
| iv_in | input | 64 | Initialization vector |
| key_p1 | input | 56 | Key for pass 1 (decrypt) |
| key_p2 | input | 56 | Key for pass 2 (encrypt) |
| key_p3 | input | 56 | Key for pass 3 (decrypt) |
| ct_valid | input | 1 | Ciphertext offered |
| ct_ready | output | 1 | Holding register free |
| ct_in | input | 64 | Ciphertext block |
| pt_valid | output | 1 | One-cycle plaintext strobe |
| pt_out | output | 64 | Plaintext block |
| busy | output | 1 | A block is held or in progress |

## Verification
The hardest state to reach from the ports has two parts at once: one block in the rounds, a second block waiting in the holding register, and `ct_ready` low. While in that state, further ciphertext must be refused.

The stimulus reaches this state by offering two blocks on consecutive opportunities. It then keeps `ct_valid` high with junk data for ten cycles while ready is low. Afterwards it confirms that exactly two plaintexts appear and that their chained values match the model.

The independent model computes the expected values for several key sets, including two-key and all-equal cases. It builds its key schedule forward, then indexes that schedule backwards.

// File: rtl/tdes_cbc_dec.sv
module tdes_cbc_dec (
  input  logic        clk,
  input  logic        rst_n,
  input  logic        iv_load,
  input  logic [63:0] iv_in,
  input  logic [55:0] key_p1,
  input  logic [55:0] key_p2,
  input  logic [55:0] key_p3,
  input  logic        ct_valid,
  output logic        ct_ready,
  input  logic [63:0] ct_in,
  output logic        pt_valid,
  output logic [63:0] pt_out,
  output logic        busy
);

  localparam int P_T [32] = '{16, 7, 20, 21, 29, 12, 28, 17, 1, 15, 23, 26, 5, 18, 31, 10,
                              2, 8, 24, 14, 32, 27, 3, 9, 19, 13, 30, 6, 22, 11, 4, 25};

  localparam int PC1_T [56] = '{57, 49, 41, 33, 25, 17, 9, 1, 58, 50, 42, 34, 26, 18,
                                10, 2, 59, 51, 43, 35, 27, 19, 11, 3, 60, 52, 44, 36,
                                63, 55, 47, 39, 31, 23, 15, 7, 62, 54, 46, 38, 30, 22,
                                14, 6, 61, 53, 45, 37, 29, 21, 13, 5, 28, 20, 12, 4};

  localparam int PC2_T [48] = '{14, 17, 11, 24, 1, 5, 3, 28, 15, 6, 21, 10,
                                23, 19, 12, 4, 26, 8, 16, 7, 27, 20, 13, 2,
                                41, 52, 31, 37, 47, 55, 30, 40, 51, 45, 33, 48,
                                44, 49, 39, 56, 34, 53, 46, 42, 50, 36, 29, 32};

  localparam logic [255:0] SBOX [8] = '{
    256'hE4D12FB83A6C5907_0F74E2D1A6CB9538_41E8D62BFC973A50_FC8249175B3EA06D,
    256'hF18E6B34972DC05A_3D47F28EC01A69B5_0E7BA4D158C6932F_D8A13F42B67C05E9,
    256'hA09E63F51DC7B428_D709346A285ECBF1_D6498F30B12C5AE7_1AD069874FE3B52C,
    256'h7DE3069A1285BC4F_D8B56F03472C1AE9_A690CB7DF13E5284_3F06A1D8945BC72E,
    256'h2C417AB6853FD0E9_EB2C47D150FA3986_421BAD78F9C5630E_B8C71E2D6F09A453,
    256'hC1AF92680D34E75B_AF427C9561DE0B38_9EF528C3704A1DB6_432C95FABE17608D,
    256'h4B2EF08D3C975A61_D0B7491AE35C2F86_14BDC37EAF680592_6BD814A7950FE23C,
    256'hD2846FB1A93E50C7_1FD8A374C56B0E92_7B419CE206ADF358_21E74A8DFC90356B};

  function automatic int ip_src(input int i);
    int r, c;
    r = i / 8;
    c = i % 8;
    return (r < 4) ? (58 + 2*r - 8*c) : (57 + 2*(r-4) - 8*c);
  endfunction

  function automatic logic [63:0] ip_f(input logic [63:0] x);
    logic [63:0] y;
    for (int i = 0; i < 64; i++) y[63-i] = x[64-ip_src(i)];
    return y;
  endfunction

  function automatic logic [63:0] fp_f(input logic [63:0] x);
    logic [63:0] y;
    for (int i = 0; i < 64; i++) y[64-ip_src(i)] = x[63-i];
    return y;
  endfunction

  function automatic logic [31:0] feistel(input logic [31:0] r, input logic [47:0] k);
    logic [47:0] e;
    logic [31:0] s, y;
    logic [5:0]  a;
    for (int j = 0; j < 48; j++) e[47-j] = r[31 - ((4*(j/6) + j%6 + 31) % 32)];
    e = e ^ k;
    for (int n = 0; n < 8; n++) begin
      a = e[47-6*n -: 6];
      s[31-4*n -: 4] = SBOX[n][(63 - {26'd0, a[5], a[0], a[4:1]})*4 +: 4];
    end
    for (int i = 0; i < 32; i++) y[31-i] = s[32-P_T[i]];
    return y;
  endfunction

  function automatic logic [55:0] pc1_f(input logic [55:0] k);
    logic [63:0] w;
    logic [55:0] y;
    for (int b = 0; b < 8; b++) w[63-8*b -: 8] = {k[55-7*b -: 7], 1'b0};
    for (int i = 0; i < 56; i++) y[55-i] = w[64-PC1_T[i]];
    return y;
  endfunction

  function automatic logic [47:0] pc2_f(input logic [55:0] cd);
    logic [47:0] y;
    for (int i = 0; i < 48; i++) y[47-i] = cd[56-PC2_T[i]];
    return y;
  endfunction

  function automatic logic [27:0] rotl(input logic [27:0] x, input logic one);
    return one ? {x[26:0], x[27]} : {x[25:0], x[27:26]};
  endfunction

  function automatic logic [27:0] rotr(input logic [27:0] x, input logic one);
    return one ? {x[0], x[27:1]} : {x[1:0], x[27:2]};
  endfunction

  logic [63:0] hold, cur_ct, prev_ct, st;
  logic        hold_v, run;
  logic [55:0] cd;
  logic [3:0]  rnd;
  logic [1:0]  pass;

  logic        dec, one, last_r;
  logic [55:0] cd_l, cd_r, kcd, next_key;
  logic [63:0] rout, blk_res;

  assign dec      = (pass != 2'd1);
  assign one      = dec ? (rnd == 4'd0 || rnd == 4'd7 || rnd == 4'd14 || rnd == 4'd15)
                        : (rnd == 4'd0 || rnd == 4'd1 || rnd == 4'd8 || rnd == 4'd15);
  assign cd_l     = {rotl(cd[55:28], one), rotl(cd[27:0], one)};
  assign cd_r     = {rotr(cd[55:28], one), rotr(cd[27:0], one)};
  assign kcd      = dec ? cd : cd_l;
  assign rout     = {st[31:0], st[63:32] ^ feistel(st[31:0], pc2_f(kcd))};
  assign blk_res  = fp_f({rout[31:0], rout[63:32]});
  assign last_r   = (rnd == 4'd15);
  assign next_key = (pass == 2'd0) ? key_p2 : key_p3;

  assign ct_ready = !hold_v;
  assign busy     = run | hold_v;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      hold     <= '0;
      hold_v   <= 1'b0;
      cur_ct   <= '0;
      prev_ct  <= '0;
      st       <= '0;
      cd       <= '0;
      rnd      <= '0;
      pass     <= '0;
      run      <= 1'b0;
      pt_valid <= 1'b0;
      pt_out   <= '0;
    end else begin
      pt_valid <= 1'b0;
      if (ct_valid && ct_ready) begin
        hold   <= ct_in;
        hold_v <= 1'b1;
      end
      if (!run && hold_v) begin
        st     <= ip_f(hold);
        cur_ct <= hold;
        cd     <= pc1_f(key_p1);
        rnd    <= '0;
        pass   <= '0;
        run    <= 1'b1;
        hold_v <= 1'b0;
      end else if (run) begin
        rnd <= rnd + 4'd1;
        if (last_r && pass == 2'd2) begin
          run      <= 1'b0;
          pt_valid <= 1'b1;
          pt_out   <= blk_res ^ prev_ct;
          prev_ct  <= cur_ct;
        end else if (last_r) begin
          st   <= ip_f(blk_res);
          cd   <= pc1_f(next_key);
          pass <= pass + 2'd1;
        end else begin
          st <= rout;
          cd <= dec ? cd_r : cd_l;
        end
      end
      if (iv_load) prev_ct <= iv_in;
    end
  end

endmodule

// File: rtl/tdes_cbc_dec_chk.sv
module tdes_cbc_dec_chk (
  input logic clk,
  input logic rst_n,
  input logic ct_valid,
  input logic ct_ready,
  input logic pt_valid,
  input logic busy,
  input logic run
);

  logic [6:0] rc;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) rc <= '0;
    else        rc <= run ? rc + 7'd1 : 7'd0;
  end

  // R5
  latency_chk: assert property (@(posedge clk) disable iff (!rst_n) pt_valid |-> rc == 7'd48);

  // R5
  round_bound_chk: assert property (@(posedge clk) disable iff (!rst_n) run |-> rc < 7'd48);

  // R7
  single_pulse_chk: assert property (@(posedge clk) disable iff (!rst_n) pt_valid |=> !pt_valid);

  // R6
  accept_busy_chk: assert property (@(posedge clk) disable iff (!rst_n) (ct_valid && ct_ready) |=> busy);

  // R10
  busy_fall_chk: assert property (@(posedge clk) disable iff (!rst_n) $fell(busy) |-> pt_valid);

  // R1
  idle_ready_chk: assert property (@(posedge clk) disable iff (!rst_n) !busy |-> ct_ready);

endmodule

bind tdes_cbc_dec tdes_cbc_dec_chk u_chk (
  .clk(clk), .rst_n(rst_n), .ct_valid(ct_valid), .ct_ready(ct_ready),
  .pt_valid(pt_valid), .busy(busy), .run(run)
);

// File: tb/tb_tdes_cbc_dec.sv
module tb_tdes_cbc_dec;

  localparam int TIP [64] = '{58, 50, 42, 34, 26, 18, 10, 2, 60, 52, 44, 36, 28, 20, 12, 4,
                              62, 54, 46, 38, 30, 22, 14, 6, 64, 56, 48, 40, 32, 24, 16, 8,
                              57, 49, 41, 33, 25, 17, 9, 1, 59, 51, 43, 35, 27, 19, 11, 3,
                              61, 53, 45, 37, 29, 21, 13, 5, 63, 55, 47, 39, 31, 23, 15, 7};
  localparam int TFP [64] = '{40, 8, 48, 16, 56, 24, 64, 32, 39, 7, 47, 15, 55, 23, 63, 31,
                              38, 6, 46, 14, 54, 22, 62, 30, 37, 5, 45, 13, 53, 21, 61, 29,
                              36, 4, 44, 12, 52, 20, 60, 28, 35, 3, 43, 11, 51, 19, 59, 27,
                              34, 2, 42, 10, 50, 18, 58, 26, 33, 1, 41, 9, 49, 17, 57, 25};
  localparam int TE [48] = '{32, 1, 2, 3, 4, 5, 4, 5, 6, 7, 8, 9, 8, 9, 10, 11, 12, 13,
                             12, 13, 14, 15, 16, 17, 16, 17, 18, 19, 20, 21, 20, 21, 22, 23, 24, 25,
                             24, 25, 26, 27, 28, 29, 28, 29, 30, 31, 32, 1};
  localparam int TP [32] = '{16, 7, 20, 21, 29, 12, 28, 17, 1, 15, 23, 26, 5, 18, 31, 10,
                             2, 8, 24, 14, 32, 27, 3, 9, 19, 13, 30, 6, 22, 11, 4, 25};
  localparam int TPC1 [56] = '{57, 49, 41, 33, 25, 17, 9, 1, 58, 50, 42, 34, 26, 18,
                               10, 2, 59, 51, 43, 35, 27, 19, 11, 3, 60, 52, 44, 36,
                               63, 55, 47, 39, 31, 23, 15, 7, 62, 54, 46, 38, 30, 22,
                               14, 6, 61, 53, 45, 37, 29, 21, 13, 5, 28, 20, 12, 4};
  localparam int TPC2 [48] = '{14, 17, 11, 24, 1, 5, 3, 28, 15, 6, 21, 10,
                               23, 19, 12, 4, 26, 8, 16, 7, 27, 20, 13, 2,
                               41, 52, 31, 37, 47, 55, 30, 40, 51, 45, 33, 48,
                               44, 49, 39, 56, 34, 53, 46, 42, 50, 36, 29, 32};
  localparam logic [255:0] TS [8] = '{
    256'hE4D12FB83A6C5907_0F74E2D1A6CB9538_41E8D62BFC973A50_FC8249175B3EA06D,
    256'hF18E6B34972DC05A_3D47F28EC01A69B5_0E7BA4D158C6932F_D8A13F42B67C05E9,
    256'hA09E63F51DC7B428_D709346A285ECBF1_D6498F30B12C5AE7_1AD069874FE3B52C,
    256'h7DE3069A1285BC4F_D8B56F03472C1AE9_A690CB7DF13E5284_3F06A1D8945BC72E,
    256'h2C417AB6853FD0E9_EB2C47D150FA3986_421BAD78F9C5630E_B8C71E2D6F09A453,
    256'hC1AF92680D34E75B_AF427C9561DE0B38_9EF528C3704A1DB6_432C95FABE17608D,
    256'h4B2EF08D3C975A61_D0B7491AE35C2F86_14BDC37EAF680592_6BD814A7950FE23C,
    256'hD2846FB1A93E50C7_1FD8A374C56B0E92_7B419CE206ADF358_21E74A8DFC90356B};

  // stimulus: k1, k2, k3 (64-bit form), iv, c0, c1, c2
  localparam int NV = 4;
  localparam logic [447:0] VEC [NV] = '{
    {64'h133457799BBCDFF1, 64'h133457799BBCDFF1, 64'h133457799BBCDFF1, 64'h0,
     64'h85E813540F0AB405, 64'h0123456789ABCDEF, 64'h85E813540F0AB405},
    {64'h0123456789ABCDEF, 64'h23456789ABCDEF01, 64'h456789ABCDEF0123, 64'hF0E1D2C3B4A59687,
     64'h6BFFA1D3B2C09E41, 64'h0000000000000000, 64'hFFFFFFFFFFFFFFFF},
    {64'h0E329232EA6D0D73, 64'h8001FEDCBA987654, 64'h0E329232EA6D0D73, 64'h0000000000000001,
     64'h1122334455667788, 64'h99AABBCCDDEEFF00, 64'h5A5A5A5AA5A5A5A5},
    {64'h0, 64'h0, 64'h0, 64'hFFFFFFFFFFFFFFFF,
     64'hDEADBEEFCAFEF00D, 64'h0F1E2D3C4B5A6978, 64'h8000000000000001}};

  logic        clk = 1'b0, rst_n = 1'b0;
  logic        iv_load = 1'b0, ct_valid = 1'b0;
  logic [63:0] iv_in = '0, ct_in = '0;
  logic [55:0] key_p1 = '0, key_p2 = '0, key_p3 = '0;
  logic        ct_ready, pt_valid, busy;
  logic [63:0] pt_out;

  int checks = 0, fails = 0;
  logic [63:0] got [64];
  time         got_t [64];
  int          n_out = 0;
  time         acc_t;
  bit          was_valid = 1'b0;
  logic [63:0] last_pt;

  always #10 clk = ~clk;

  tdes_cbc_dec dut (
    .clk(clk), .rst_n(rst_n), .iv_load(iv_load), .iv_in(iv_in),
    .key_p1(key_p1), .key_p2(key_p2), .key_p3(key_p3),
    .ct_valid(ct_valid), .ct_ready(ct_ready), .ct_in(ct_in),
    .pt_valid(pt_valid), .pt_out(pt_out), .busy(busy));

  task automatic chk(input bit ok, input string req, input logic [63:0] act, input logic [63:0] exp);
    checks++;
    if (!ok) begin
      fails++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  task automatic report();
    $display("  *** SUMMARY: %0d compared / %0d mismatched ***", checks, fails);
    $finish;
  endtask

  function automatic logic [55:0] strip(input logic [63:0] k);
    logic [55:0] y;
    for (int b = 0; b < 8; b++) y[55-7*b -: 7] = k[63-8*b -: 7];
    return y;
  endfunction

  function automatic logic [63:0] m_des(input logic [63:0] blk, input logic [63:0] key, input bit inv);
    logic [55:0] cd;
    logic [47:0] ks [16];
    logic [47:0] e;
    logic [63:0] t, y;
    logic [31:0] l, r, so, fo, tmp;
    logic [5:0]  a;
    int sh;
    for (int i = 0; i < 56; i++) cd[55-i] = key[64-TPC1[i]];
    for (int i = 0; i < 16; i++) begin
      sh = (i == 0 || i == 1 || i == 8 || i == 15) ? 1 : 2;
      for (int s = 0; s < sh; s++) cd = {cd[54:28], cd[55], cd[26:0], cd[27]};
      for (int j = 0; j < 48; j++) ks[i][47-j] = cd[56-TPC2[j]];
    end
    for (int i = 0; i < 64; i++) t[63-i] = blk[64-TIP[i]];
    l = t[63:32];
    r = t[31:0];
    for (int i = 0; i < 16; i++) begin
      for (int j = 0; j < 48; j++) e[47-j] = r[32-TE[j]];
      e = e ^ ks[inv ? 15-i : i];
      for (int n = 0; n < 8; n++) begin
        a = e[47-6*n -: 6];
        so[31-4*n -: 4] = TS[n][(63 - (32*int'(a[5]) + 16*int'(a[0]) + int'(a[4:1])))*4 +: 4];
      end
      for (int j = 0; j < 32; j++) fo[31-j] = so[32-TP[j]];
      tmp = r;
      r = l ^ fo;
      l = tmp;
    end
    t = {r, l};
    for (int i = 0; i < 64; i++) y[63-i] = t[64-TFP[i]];
    return y;
  endfunction

  function automatic logic [63:0] m_tdes(input logic [63:0] c, input logic [63:0] k1,
                                         input logic [63:0] k2, input logic [63:0] k3);
    return m_des(m_des(m_des(c, k1, 1'b1), k2, 1'b0), k3, 1'b1);
  endfunction

  always @(negedge clk) begin
    if (was_valid) begin
      chk(!pt_valid, "R7 pulse width", {63'd0, pt_valid}, 64'd0);
      chk(pt_out == last_pt, "R7 hold", pt_out, last_pt);
    end
    was_valid = pt_valid;
    if (pt_valid) begin
      last_pt = pt_out;
      got[n_out % 64] = pt_out;
      got_t[n_out % 64] = $time;
      n_out++;
    end
  end

  task automatic set_keys(input int v);
    key_p1 = strip(VEC[v][447:384]);
    key_p2 = strip(VEC[v][383:320]);
    key_p3 = strip(VEC[v][319:256]);
  endtask

  task automatic load_iv(input logic [63:0] iv);
    @(negedge clk);
    iv_load = 1'b1;
    iv_in   = iv;
    @(negedge clk);
    iv_load = 1'b0;
  endtask

  task automatic send(input logic [63:0] c);
    @(negedge clk);
    while (!ct_ready) @(negedge clk);
    ct_valid = 1'b1;
    ct_in    = c;
    acc_t    = $time;
    @(negedge clk);
    ct_valid = 1'b0;
  endtask

  task automatic wait_out(input int n);
    int guard = 0;
    while (n_out < n && guard < 400) begin
      @(negedge clk);
      guard++;
    end
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    chk(1'b0, "R5 watchdog", 64'd0, 64'd1);
    report();
  end

  initial begin
    logic [63:0] k1, k2, k3, iv, prev, exp;
    logic [63:0] c [3];
    int base;

    repeat (3) @(negedge clk);
    // R1
    chk(!pt_valid && !busy && ct_ready, "R1 during reset", {61'd0, pt_valid, busy, ct_ready}, 64'd1);
    rst_n = 1'b1;
    repeat (2) @(negedge clk);
    chk(!pt_valid && !busy && ct_ready, "R1 after reset", {61'd0, pt_valid, busy, ct_ready}, 64'd1);

    // R4 model sanity against the known-answer pair
    chk(m_des(64'h0123456789ABCDEF, 64'h133457799BBCDFF1, 1'b0) == 64'h85E813540F0AB405,
        "R4 model", m_des(64'h0123456789ABCDEF, 64'h133457799BBCDFF1, 1'b0), 64'h85E813540F0AB405);

    for (int v = 0; v < NV; v++) begin
      k1 = VEC[v][447:384]; k2 = VEC[v][383:320]; k3 = VEC[v][319:256];
      iv = VEC[v][255:192];
      c[0] = VEC[v][191:128]; c[1] = VEC[v][127:64]; c[2] = VEC[v][63:0];
      set_keys(v);
      load_iv(iv);
      base = n_out;
      for (int i = 0; i < 3; i++) send(c[i]);
      // R10
      chk(busy, "R10 busy during stream", {63'd0, busy}, 64'd1);
      wait_out(base + 3);
      chk(n_out == base + 3, "R6 output count", 64'(n_out - base), 64'd3);
      prev = iv;
      for (int i = 0; i < 3; i++) begin
        exp = m_tdes(c[i], k1, k2, k3) ^ prev;
        // R2 R3
        chk(got[(base + i) % 64] == exp, "R2 R3 chained plaintext", got[(base + i) % 64], exp);
        prev = c[i];
      end
      if (v == 0)
        chk(got[base % 64] == 64'h0123456789ABCDEF, "R4 single DES", got[base % 64], 64'h0123456789ABCDEF);
      chk(got_t[(base + 1) % 64] - got_t[base % 64] == 980, "R6 spacing",
          64'(got_t[(base + 1) % 64] - got_t[base % 64]), 64'd980);
      @(negedge clk);
      chk(!busy, "R10 idle after stream", {63'd0, busy}, 64'd0);

      // R8: reload IV and resend the first block
      load_iv(iv);
      base = n_out;
      send(c[0]);
      wait_out(base + 1);
      chk(got[base % 64] == got[(base - 3) % 64], "R8 restart chain", got[base % 64], got[(base - 3) % 64]);
      // R5
      chk(got_t[base % 64] - acc_t == 1000, "R5 latency", 64'(got_t[base % 64] - acc_t), 64'd1000);
    end

    // R9: offer junk while the holding register is full
    set_keys(1);
    k1 = VEC[1][447:384]; k2 = VEC[1][383:320]; k3 = VEC[1][319:256];
    load_iv(64'h0011223344556677);
    base = n_out;
    send(64'hA5A5A5A5A5A5A5A5);
    send(64'h3C3C3C3C3C3C3C3C);
    for (int i = 0; i < 10; i++) begin
      @(negedge clk);
      chk(!ct_ready, "R9 ready low", {63'd0, ct_ready}, 64'd0);
      ct_valid = 1'b1;
      ct_in    = 64'hBAD0BAD0BAD00000 + 64'(i);
    end
    @(negedge clk);
    ct_valid = 1'b0;
    wait_out(base + 2);
    repeat (120) @(negedge clk);
    chk(n_out == base + 2, "R9 no extra block", 64'(n_out - base), 64'd2);
    exp = m_tdes(64'hA5A5A5A5A5A5A5A5, k1, k2, k3) ^ 64'h0011223344556677;
    chk(got[base % 64] == exp, "R9 first block", got[base % 64], exp);
    exp = m_tdes(64'h3C3C3C3C3C3C3C3C, k1, k2, k3) ^ 64'hA5A5A5A5A5A5A5A5;
    chk(got[(base + 1) % 64] == exp, "R9 second block", got[(base + 1) % 64], exp);
    chk(!busy && ct_ready, "R10 idle at end", {62'd0, busy, ct_ready}, 64'd1);

    report();
  end

endmodule